// File: doc/BRIEF.md
# Boot-Lockable Sector Map

This block sits between a flash command decoder and the array controller. It takes the byte address of each program or erase request and finds which of seven unequal sectors it falls in. A parameter selects between two layouts that mirror each other: boot sector at the bottom of the space or at the top. It also holds a one-way boot lock. Once the lock is set, programs and sector erases aimed at the boot sector are refused. A chip erase is still accepted, but its per-sector erase mask leaves the boot sector out.

The decoder hands over each request on `op_valid` with its kind and address. One clock later the block answers with either an `accept` pulse, which the controller uses to start its busy period, or a `reject` pulse. Along with the answer it reports the sector index and the set of sectors to erase. For identification reads, it supplies the bytes returned at the first four offsets of the boot region, and one of those bytes carries the lock state.

Top module: `sector_guard`

## Requirements
- R1: With `TOP_BOOT`=0, the sector index is:
  - 0 (boot) for 0x00000–0x03FFF
  - 1 for 0x04000–0x05FFF
  - 2 for 0x06000–0x07FFF
  - 3 for 0x08000–0x0FFFF
  - 4, 5 and 6 for the 64 KB ranges starting at 0x10000, 0x20000 and 0x30000.
- R2: With `TOP_BOOT`=1, the sector index is:
  - 0 (boot) for 0x3C000–0x3FFFF
  - 1 for 0x3A000–0x3BFFF
  - 2 for 0x38000–0x39FFF
  - 3 for 0x30000–0x37FFF
  - 4 for 0x20000–0x2FFFF, 5 for 0x10000–0x1FFFF and 6 for 0x00000–0x0FFFF.
- R3: `sector_out` shows the index of the `op_addr` sampled at the previous rising edge. It updates on every cycle, whatever the value of `op_valid`.
- R4: `lock_req` high at an edge sets `lock_state` from the next cycle on. The flag stays set until `rst_n` is sampled low, and repeating the request has no further effect.
- R5: With the lock set, a program (`op_kind`=1) or sector erase (`op_kind`=2) on sector 0 yields a one-cycle `reject`, no `accept`, and an all-zero `erase_mask`.
- R6: A program or sector erase that is not refused under R5 yields a one-cycle `accept`. The mask is zero for a program and has only the target sector's bit set for a sector erase, where bit i stands for sector i.
- R7: A chip erase (`op_kind`=3) is always accepted. Its mask is 0x7F with the lock clear and 0x7E with the lock set.
- R8: With `id_mode` high, reads at boot-region offsets 0, 1 and 3 return:
  - 0x1F at offset 0
  - 0x07 at offset 1 (bottom boot) or 0x08 (top boot)
  - 0x0F at offset 3.
  The region base is 0x00000 for bottom boot and 0x3C000 for top boot. `rd_data` is combinational.
- R9: With `id_mode` high, a read at boot-region offset 2 returns the lock state on bit 0 and zeros on bits 7..1.
- R10: `rd_data` is 0x00 when `id_mode` is low or the address is not one of the four offsets.
- R11: A cycle with `op_valid` low, or with `op_kind`=0, gives no `accept`, no `reject` and a zero mask on the next cycle.
- R12: While `rst_n` is sampled low, `accept`, `reject`, `erase_mask`, `sector_out` and `lock_state` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the only way to clear the lock |
| op_valid | input | 1 | Request strobe for one cycle |
| op_kind | input | 2 | 0 none, 1 program, 2 sector erase, 3 chip erase |
| op_addr | input | 18 | Byte address of the request |
| lock_req | input | 1 | Sets the boot lock |
| id_mode | input | 1 | Identification read mode |
| rd_addr | input | 18 | Read address for identification data |
| accept | output | 1 | Request granted (one-cycle pulse) |
| reject | output | 1 | Request refused (one-cycle pulse) |
| sector_out | output | 3 | Sector index of the last sampled `op_addr` |
| erase_mask | output | 7 | Sectors to erase; bit i is sector i |
| lock_state | output | 1 | Boot lock flag |
| rd_data | output | 8 | Identification read data |

## Verification
`accept`, `reject`, `erase_mask` and `sector_out` are due one rising edge after the request is sampled. `lock_state` follows `lock_req` one edge later, so a request in the same cycle as `lock_req` is still judged against the old lock. `rd_data` is due in the same cycle as its inputs. The bench changes inputs 2 ns after each rising edge and advances its reference model at the rising edge. It compares every output against the model on the falling edge, which gives each due time a single sample point away from any edge.

// File: rtl/sg_pkg.sv
// Package: shared sector indices, request kinds and identification bytes.
// Assumes seven sectors; index 0 is always the boot sector.
package sg_pkg;
    localparam int NUM_SECT = 7;
    localparam int SECT_W   = $clog2(NUM_SECT);

    typedef enum logic [SECT_W-1:0] {
        SEC_BOOT  = 3'd0,
        SEC_PAR1  = 3'd1,
        SEC_PAR2  = 3'd2,
        SEC_MAIN1 = 3'd3,
        SEC_MAIN2 = 3'd4,
        SEC_MAIN3 = 3'd5,
        SEC_MAIN4 = 3'd6
    } sect_e;

    typedef enum logic [1:0] {
        OPK_IDLE   = 2'd0,
        OPK_PROG   = 2'd1,
        OPK_SERASE = 2'd2,
        OPK_CERASE = 2'd3
    } opk_e;

    localparam logic [7:0] ID_MAKER   = 8'h1F;
    localparam logic [7:0] ID_DEV_BOT = 8'h07;
    localparam logic [7:0] ID_DEV_TOP = 8'h08;
    localparam logic [7:0] ID_EXT     = 8'h0F;
endpackage

// File: rtl/sect_decode.sv
// Module: sect_decode
// Maps a byte address to a sector index. The two layouts are exact mirrors,
// so the top-boot variant inverts the address and reuses the bottom-boot
// decode. Assumes ADDR_W >= 6; sizes scale as boot = 1/16, parameter = 1/32,
// first main = 1/8 and the other mains = 1/4 of the space.
module sect_decode
    import sg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sect
);
    localparam int BIT_MAIN1 = ADDR_W - 3;
    localparam int BIT_PARAM = ADDR_W - 4;
    localparam int BIT_PAR2  = ADDR_W - 5;

    logic [ADDR_W-1:0] norm;
    logic [1:0]        quarter;

    // Put the address into bottom-boot orientation.
    generate
        if (TOP_BOOT) begin : g_mirror
            assign norm = ~addr;
        end else begin : g_direct
            assign norm = addr;
        end
    endgenerate

    assign quarter = norm[ADDR_W-1 -: 2];

    // Decode by size class: quarters, then eighth, then parameter pair, then boot.
    always_comb begin
        if (quarter != 2'd0)
            sect = SECT_W'(SEC_MAIN1) + SECT_W'(quarter);
        else if (norm[BIT_MAIN1])
            sect = SEC_MAIN1;
        else if (norm[BIT_PARAM])
            sect = norm[BIT_PAR2] ? SEC_PAR2 : SEC_PAR1;
        else
            sect = SEC_BOOT;
    end
endmodule

// File: rtl/lock_keeper.sv
// Module: lock_keeper
// One-way boot lock flag. It is set by a request and cleared only by the
// synchronous active-low reset. Assumes the reset means power-on.
module lock_keeper (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic locked
);
    // Set the flag on request; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (set_req)
            locked <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R4
    AST_LOCK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> locked); // R4
endmodule

// File: rtl/id_readout.sv
// Module: id_readout
// Combinational identification read data. It answers the first four byte
// offsets of the boot region while id_mode is high and returns zero elsewhere.
// Assumes the boot region is the lowest or highest 1/16 of the space.
module id_readout
    import sg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              locked,
    output logic [7:0]        rd_data
);
    localparam int          REG_BITS = ADDR_W - 4;
    localparam logic [3:0]  REG_TAG  = TOP_BOOT ? 4'hF : 4'h0;
    localparam logic [7:0]  DEV_CODE = TOP_BOOT ? ID_DEV_TOP : ID_DEV_BOT;

    logic in_region;
    logic low_slot;

    assign in_region = (rd_addr[ADDR_W-1 -: 4] == REG_TAG);
    assign low_slot  = (rd_addr[REG_BITS-1:2] == '0);

    // Choose the identification byte for the addressed offset.
    always_comb begin
        rd_data = 8'h00;
        if (id_mode && in_region && low_slot) begin
            case (rd_addr[1:0])
                2'd0:    rd_data = ID_MAKER;
                2'd1:    rd_data = DEV_CODE;
                2'd2:    rd_data = {7'b0, locked};
                default: rd_data = ID_EXT;
            endcase
        end
    end
endmodule

// File: rtl/sector_guard.sv
// Module: sector_guard
// Judges program and erase requests against the sector map and the boot
// lock, and registers the verdict, sector index and erase mask. Assumes one
// request per cycle at most and a downstream controller that starts on accept.
module sector_guard
    import sg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              lock_req,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              accept,
    output logic              reject,
    output logic [SECT_W-1:0] sector_out,
    output logic [NUM_SECT-1:0] erase_mask,
    output logic              lock_state,
    output logic [7:0]        rd_data
);
    logic [SECT_W-1:0]   sec_dec;
    logic                lock_q;
    logic                live_req;
    logic                acc_d;
    logic                rej_d;
    logic [NUM_SECT-1:0] mask_d;

    sect_decode #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_decode (
        .addr (op_addr),
        .sect (sec_dec)
    );

    lock_keeper u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (lock_req),
        .locked  (lock_q)
    );

    id_readout #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_id (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .locked  (lock_q),
        .rd_data (rd_data)
    );

    assign live_req = op_valid && (op_kind != OPK_IDLE);

    // Decide accept or reject and the erase mask from the current lock state.
    always_comb begin
        acc_d  = 1'b0;
        rej_d  = 1'b0;
        mask_d = '0;
        if (live_req) begin
            if (op_kind == OPK_CERASE) begin
                acc_d  = 1'b1;
                mask_d = '1;
                if (lock_q)
                    mask_d[SEC_BOOT] = 1'b0;
            end else if (lock_q && sec_dec == SEC_BOOT) begin
                rej_d = 1'b1;
            end else begin
                acc_d = 1'b1;
                if (op_kind == OPK_SERASE)
                    mask_d[sec_dec] = 1'b1;
            end
        end
    end

    // Register verdict, mask and sector index for the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept     <= 1'b0;
            reject     <= 1'b0;
            erase_mask <= '0;
            sector_out <= '0;
        end else begin
            accept     <= acc_d;
            reject     <= rej_d;
            erase_mask <= mask_d;
            sector_out <= sec_dec;
        end
    end

    assign lock_state = lock_q;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject)); // R5
    AST_BOOT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_kind == OPK_PROG || op_kind == OPK_SERASE) && lock_q
         && sec_dec == SEC_BOOT) |=> reject); // R5
    AST_REJECT_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (erase_mask == '0)); // R5
    AST_OTHER_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (live_req && sec_dec != SEC_BOOT) |=> accept); // R6
    AST_CHIP_SPARES_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OPK_CERASE) |=>
        (accept && erase_mask[NUM_SECT-1:1] == '1)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!accept && !reject && erase_mask == '0)); // R11
endmodule

// File: tb/sector_guard_bench.sv
// Bench: drives both layouts with the same stimulus and compares every output
// on each falling edge against a behavioural reference model.
module sector_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [17:0] op_addr = '0;
    logic        lock_req = 1'b0;
    logic        id_mode = 1'b0;
    logic [17:0] rd_addr = '0;

    logic [1:0]  acc_w, rej_w, lock_w;
    logic [2:0]  sec_w [2];
    logic [6:0]  mask_w [2];
    logic [7:0]  rd_w [2];

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sector_guard #(.ADDR_W(18), .TOP_BOOT(1'b0)) u_sector_guard (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .lock_req(lock_req), .id_mode(id_mode),
        .rd_addr(rd_addr), .accept(acc_w[0]), .reject(rej_w[0]),
        .sector_out(sec_w[0]), .erase_mask(mask_w[0]),
        .lock_state(lock_w[0]), .rd_data(rd_w[0]));

    sector_guard #(.ADDR_W(18), .TOP_BOOT(1'b1)) u_sector_guard_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .lock_req(lock_req), .id_mode(id_mode),
        .rd_addr(rd_addr), .accept(acc_w[1]), .reject(rej_w[1]),
        .sector_out(sec_w[1]), .erase_mask(mask_w[1]),
        .lock_state(lock_w[1]), .rd_data(rd_w[1]));

    function automatic int ref_sector(int a, bit top);
        if (!top) begin
            if (a < 'h04000) return 0;
            if (a < 'h06000) return 1;
            if (a < 'h08000) return 2;
            if (a < 'h10000) return 3;
            if (a < 'h20000) return 4;
            if (a < 'h30000) return 5;
            return 6;
        end
        if (a >= 'h3C000) return 0;
        if (a >= 'h3A000) return 1;
        if (a >= 'h38000) return 2;
        if (a >= 'h30000) return 3;
        if (a >= 'h20000) return 4;
        if (a >= 'h10000) return 5;
        return 6;
    endfunction

    // Reference model state, advanced at each rising edge.
    int    m_sec [2];
    int    m_mask [2];
    bit    m_acc [2];
    bit    m_rej [2];
    string m_tag [2];
    bit    m_lock = 1'b0;
    bit    m_rst = 1'b1;
    bit    seen_edge = 1'b0;

    always @(posedge clk) begin
        seen_edge = 1'b1;
        m_rst = !rst_n;
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_sec[k] = 0; m_mask[k] = 0; m_acc[k] = 0; m_rej[k] = 0;
                m_tag[k] = "R12";
            end else begin
                m_sec[k] = ref_sector(int'(op_addr), k == 1);
                m_acc[k] = 0; m_rej[k] = 0; m_mask[k] = 0; m_tag[k] = "R11";
                if (op_valid && op_kind != 2'd0) begin
                    if (op_kind == 2'd3) begin
                        m_acc[k] = 1; m_mask[k] = m_lock ? 'h7E : 'h7F;
                        m_tag[k] = "R7";
                    end else if (m_lock && m_sec[k] == 0) begin
                        m_rej[k] = 1; m_tag[k] = "R5";
                    end else begin
                        m_acc[k] = 1; m_tag[k] = "R6";
                        if (op_kind == 2'd2) m_mask[k] = 1 << m_sec[k];
                    end
                end
            end
        end
        if (!rst_n) m_lock = 1'b0;
        else if (lock_req) m_lock = 1'b1;
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs of both instances on the falling edge.
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            for (int k = 0; k < 2; k++) begin
                string st;
                string rt;
                int    base;
                int    off;
                int    erd;
                st = m_rst ? "R12" : (k == 1 ? "R2/R3" : "R1/R3");
                chk(st, "sector_out", int'(sec_w[k]), m_sec[k]);
                chk(m_tag[k], "accept", int'(acc_w[k]), int'(m_acc[k]));
                chk(m_tag[k], "reject", int'(rej_w[k]), int'(m_rej[k]));
                chk(m_tag[k], "erase_mask", int'(mask_w[k]), m_mask[k]);
                chk(m_rst ? "R12" : "R4", "lock_state", int'(lock_w[k]), int'(m_lock));
                base = (k == 1) ? 'h3C000 : 0;
                off = int'(rd_addr) - base;
                erd = 0; rt = "R10";
                if (id_mode && off >= 0 && off < 4) begin
                    case (off)
                        0: begin erd = 'h1F; rt = "R8"; end
                        1: begin erd = (k == 1) ? 'h08 : 'h07; rt = "R8"; end
                        2: begin erd = int'(m_lock); rt = "R9"; end
                        default: begin erd = 'h0F; rt = "R8"; end
                    endcase
                end
                chk(rt, "rd_data", int'(rd_w[k]), erd);
            end
        end
    end

    task automatic drive(bit v, int kind, int a, bit lk, bit idm, int ra);
        @(posedge clk);
        #2;
        op_valid = v; op_kind = kind[1:0]; op_addr = a[17:0];
        lock_req = lk; id_mode = idm; rd_addr = ra[17:0];
    endtask

    initial begin
        int edges [20] = '{'h00000, 'h03FFF, 'h04000, 'h05FFF, 'h06000,
                           'h07FFF, 'h08000, 'h0FFFF, 'h10000, 'h1FFFF,
                           'h20000, 'h2FFFF, 'h30000, 'h37FFF, 'h38000,
                           'h39FFF, 'h3A000, 'h3BFFF, 'h3C000, 'h3FFFF};
        // R12: reset state with a live request present.
        drive(1, 1, 'h00100, 0, 0, 0);
        drive(1, 2, 'h3C100, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        // R1, R2, R6: programs and sector erases across every boundary.
        foreach (edges[i]) drive(1, 1, edges[i], 0, 0, 0);
        foreach (edges[i]) drive(1, 2, edges[i], 0, 0, 0);
        // R11: no request, and a kind of zero with the strobe high.
        drive(0, 2, 'h00000, 0, 0, 0);
        drive(1, 0, 'h3C000, 0, 0, 0);
        // R7: chip erase with the lock clear.
        drive(1, 3, 'h12345, 0, 0, 0);
        // R8, R9, R10: identification reads, both regions, unlocked.
        for (int o = 0; o < 6; o++) drive(0, 0, 0, 0, 1, o);
        for (int o = 0; o < 6; o++) drive(0, 0, 0, 0, 1, 'h3C000 + o);
        drive(0, 0, 0, 0, 0, 'h00000);
        drive(0, 0, 0, 0, 1, 'h04000);
        // R4: lock request together with a boot program, still judged unlocked.
        drive(1, 1, 'h00010, 1, 0, 0);
        drive(1, 1, 'h3C010, 0, 0, 0);
        // R5, R6: locked boot refused, other sectors still granted.
        drive(1, 1, 'h00010, 0, 0, 0);
        drive(1, 2, 'h03FFF, 0, 0, 0);
        drive(1, 2, 'h3FFFF, 0, 0, 0);
        drive(1, 2, 'h04000, 0, 0, 0);
        drive(1, 1, 'h3BFFF, 0, 0, 0);
        // R7: chip erase with the lock set.
        drive(1, 3, 'h00000, 0, 0, 0);
        // R9: lock visible at offset 2.
        drive(0, 0, 0, 0, 1, 'h00002);
        drive(0, 0, 0, 0, 1, 'h3C002);
        // R4: repeated request and idle boot strobe change nothing.
        drive(0, 2, 'h00000, 1, 0, 0);
        drive(0, 0, 0, 0, 1, 'h00002);
        // R4, R12: reset clears the lock; boot becomes writable again.
        rst_n = 1'b0;
        drive(1, 1, 'h00000, 0, 1, 'h00002);
        drive(0, 0, 0, 0, 1, 'h3C002);
        rst_n = 1'b1;
        drive(1, 2, 'h00000, 0, 1, 'h00002);
        drive(1, 2, 'h3C000, 0, 1, 'h3C002);
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule